// File: doc/BRIEF.md
# Keyed watchdog timer with write-once mode

This block is a watchdog counter on a small CPU bus. It has two registers. The mode register picks the count clock source and the overflow period. The key register restarts the count when software writes the correct key byte to it. The timer runs from the moment reset is released. It counts strobes from the internal oscillator and uses the longest period. Software may configure it once. After that, any attempt to rewrite the mode, write a wrong key, or use a single-bit access is treated as a runaway program. Such an attempt pulses the reset request, unless the timer has been stopped.

The count clocks arrive as single-cycle enable strobes in the system clock domain. A halt input models the low-power states. While halt is high the count freezes, and it continues from the held value once halt is released. The reset request is a registered one-cycle pulse for the chip's reset tree. The reset tree is expected to reset this block in turn.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the mode register reads 0x67 and the reset request is low. The counter counts every internal strobe from the first cycle after reset and overflows after 2^(BASE_EXP+7) of them.
- R2: The period code n in mode bits 2..0 sets the overflow at the 2^(BASE_EXP+n)-th selected strobe after the count was last cleared. The reset request goes high in the cycle after the strobe that overflows, and the count then starts again from 0.
- R3: Mode bits 4..3 select the strobe: 00 gives the internal strobe, 01 gives the external strobe, and 1x stops counting (bit 3 is ignored when bit 4 is 1). The strobe that is not selected has no effect.
- R4: The first byte-wide write to the mode register (address 0) stores the byte, which reads back on the data output. It also clears the count to 0.
- R5: A byte-wide mode write after the first one leaves the mode unchanged and raises the reset request in the next cycle.
- R6: A byte-wide write of 0xAC to the key register (address 1) clears the count to 0 and raises no reset request.
- R7: A byte-wide key write of any value other than 0xAC raises the reset request in the next cycle.
- R8: A write with the bit-access flag set raises the reset request in the next cycle, to either address. A bit-access mode write neither stores nor uses up the single mode write.
- R9: While the mode selects the stopped option, neither overflow nor any misuse raises the reset request.
- R10: While halt is high, no strobe is counted. The count held at the start of the halt is kept, and counting resumes from it on release.
- R11: Each cause produces a reset request exactly one system clock wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 1 | Register select: 0 mode, 1 key |
| bus_wdata | input | 8 | Write data |
| bus_bit | input | 1 | Write is a single-bit access |
| bus_rdata | output | 8 | Mode register value |
| int_tick | input | 1 | Internal oscillator count strobe |
| ext_tick | input | 1 | External clock count strobe |
| halt | input | 1 | Freeze counting (low-power state) |
| wdt_rst_req | output | 1 | Reset request pulse |

## Verification
The count itself cannot be seen directly. A wrong count, a wrong terminal value or a missed clear therefore shows up only as the reset request arriving at the wrong cycle. The bench counts cycles from a known clear point and compares the result with the exact power of two. A wrong count becomes visible only at the next overflow, up to 2^(BASE_EXP+n) strobes later. A mis-decoded write or misuse flag shows up one cycle after the bus access, either as a missing or extra request or as a changed mode readback.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int PER_W = 3;
  localparam logic       ADDR_MODE = 1'b0;
  localparam logic       ADDR_KEY  = 1'b1;
  localparam logic [7:0] KEY_BYTE  = 8'hAC;
  localparam logic [7:0] MODE_INIT = 8'h67;

  typedef enum logic [1:0] {
    SRC_INT = 2'b00,
    SRC_EXT = 2'b01,
    SRC_OFF = 2'b10
  } src_e;
endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic       addr,
  input  logic [7:0] wdata,
  input  logic       bit_acc,
  output logic [7:0] mode_q,
  output logic       cnt_clr,
  output logic       misuse
);
  logic locked;
  logic mode_wr, key_wr, take_mode, good_key, bad_acc, stopped;

  always_comb begin
    mode_wr   = we && (addr == ADDR_MODE);
    key_wr    = we && (addr == ADDR_KEY);
    stopped   = mode_q[4];
    take_mode = mode_wr && !bit_acc && !locked;
    good_key  = key_wr && !bit_acc && (wdata == KEY_BYTE);
    bad_acc   = (mode_wr && (bit_acc || locked)) ||
                (key_wr && (bit_acc || (wdata != KEY_BYTE)));
    misuse    = bad_acc && !stopped;
    cnt_clr   = take_mode || good_key;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_INIT;
      locked <= 1'b0;
    end else if (take_mode) begin
      mode_q <= wdata;
      locked <= 1'b1;
    end
  end
endmodule

// File: rtl/kwdt_clksel.sv
module kwdt_clksel
  import kwdt_pkg::*;
(
  input  logic [1:0] src_sel,
  input  logic       int_tick,
  input  logic       ext_tick,
  input  logic       halt,
  output logic       cnt_en
);
  src_e src;

  always_comb begin
    if (src_sel[1]) src = SRC_OFF;
    else if (src_sel[0]) src = SRC_EXT;
    else src = SRC_INT;

    unique case (src)
      SRC_INT: cnt_en = int_tick && !halt;
      SRC_EXT: cnt_en = ext_tick && !halt;
      default: cnt_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
  import kwdt_pkg::*;
#(
  parameter int BASE_EXP = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [PER_W-1:0] per_sel,
  output logic             ovf
);
  localparam int MAX_SEL = (1 << PER_W) - 1;
  localparam int CNT_W   = BASE_EXP + MAX_SEL;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] term;

  always_comb begin
    term = {CNT_W{1'b1}} >> (MAX_SEL - int'(per_sel));
    ovf  = en && !clr && (cnt == term);
  end

  always_ff @(posedge clk) begin
    if (rst || clr || ovf) cnt <= '0;
    else if (en) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwdt_pkg::*;
#(
  parameter int BASE_EXP = 11
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_we,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_bit,
  output logic [7:0] bus_rdata,
  input  logic       int_tick,
  input  logic       ext_tick,
  input  logic       halt,
  output logic       wdt_rst_req
);
  logic [7:0] mode_q;
  logic       cnt_clr, misuse, cnt_en, ovf;

  kwdt_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (bus_we),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .bit_acc (bus_bit),
    .mode_q  (mode_q),
    .cnt_clr (cnt_clr),
    .misuse  (misuse)
  );

  kwdt_clksel u_clksel (
    .src_sel  (mode_q[4:3]),
    .int_tick (int_tick),
    .ext_tick (ext_tick),
    .halt     (halt),
    .cnt_en   (cnt_en)
  );

  kwdt_counter #(.BASE_EXP(BASE_EXP)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (cnt_clr),
    .en      (cnt_en),
    .per_sel (mode_q[PER_W-1:0]),
    .ovf     (ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) wdt_rst_req <= 1'b0;
    else     wdt_rst_req <= misuse || ovf;
  end

  assign bus_rdata = mode_q;
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_we,
  input logic       bus_addr,
  input logic [7:0] bus_wdata,
  input logic       bus_bit,
  input logic [7:0] bus_rdata,
  input logic       wdt_rst_req
);
  logic seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else if (bus_we && !bus_addr && !bus_bit) seen <= 1'b1;
  end

  // R1
  reset_mode_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bus_rdata == 8'h67 && !wdt_rst_req));

  // R5
  second_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !bus_addr && !bus_bit && seen && !bus_rdata[4]) |=> wdt_rst_req);

  // R5
  mode_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(seen)) |-> $stable(bus_rdata));

  // R7
  wrong_key_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr && bus_wdata != 8'hAC && !bus_rdata[4]) |=> wdt_rst_req);

  // R8
  bit_access_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_bit && !bus_rdata[4]) |=> wdt_rst_req);

  // R9
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rdata[4]) |-> !wdt_rst_req);
endmodule

bind keyed_wdt kwdt_chk i_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_bit     (bus_bit),
  .bus_rdata   (bus_rdata),
  .wdt_rst_req (wdt_rst_req)
);

// File: tb/test_keyed_wdt.sv
module test_keyed_wdt;
  localparam int B = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic       bus_bit = 1'b0;
  logic [7:0] bus_rdata;
  logic       int_tick = 1'b0;
  logic       ext_tick = 1'b0;
  logic       halt = 1'b0;
  logic       wdt_rst_req;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  keyed_wdt #(.BASE_EXP(B)) i_keyed_wdt (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_bit(bus_bit), .bus_rdata(bus_rdata),
    .int_tick(int_tick), .ext_tick(ext_tick), .halt(halt),
    .wdt_rst_req(wdt_rst_req)
  );

  typedef struct packed {
    logic       addr;
    logic       bitf;
    logic [7:0] data;
    logic       exp_req;
    logic [7:0] exp_mode;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 1'b0, 8'hAC, 1'b0, 8'h67},
    '{1'b1, 1'b0, 8'hAB, 1'b1, 8'h67},
    '{1'b1, 1'b0, 8'h00, 1'b1, 8'h67},
    '{1'b1, 1'b1, 8'hAC, 1'b1, 8'h67},
    '{1'b0, 1'b0, 8'h62, 1'b0, 8'h62},
    '{1'b0, 1'b1, 8'h60, 1'b1, 8'h67}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic bus_write(input logic a, input logic b, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_bit = b; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_bit = 1'b0;
  endtask

  // counts edges until the request is seen; returns limit+1 if none
  task automatic measure(input int limit, output int n);
    n = limit + 1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (wdt_rst_req) begin n = i; break; end
    end
  endtask

  task automatic quiet(input int cycles, input string req);
    int hits = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (wdt_rst_req) hits++;
    end
    check(hits == 0, req, hits, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;

    // R1: reset state and default period from the internal strobe
    int_tick = 1'b1;
    do_reset();
    check(bus_rdata == 8'h67, "R1", bus_rdata, 8'h67);
    check(wdt_rst_req == 1'b0, "R1", wdt_rst_req, 0);
    measure(5000, n);
    check(n == (1 << (B + 7)), "R1", n, 1 << (B + 7));
    // R11: one cycle wide, then count restarts (R2)
    @(negedge clk);
    check(wdt_rst_req == 1'b0, "R11", wdt_rst_req, 0);
    measure(5000, n);
    check(n == (1 << (B + 7)) - 1, "R2 restart", n, (1 << (B + 7)) - 1);

    // vector table: one write after reset, check request and mode
    foreach (VECS[k]) begin
      do_reset();
      bus_write(VECS[k].addr, VECS[k].bitf, VECS[k].data);
      check(wdt_rst_req == VECS[k].exp_req, "R6/R7/R8/R4 vector", wdt_rst_req, VECS[k].exp_req);
      check(bus_rdata == VECS[k].exp_mode, "R4/R8 vector mode", bus_rdata, VECS[k].exp_mode);
    end

    // R2/R4: period codes 0 and 3
    do_reset();
    bus_write(1'b0, 1'b0, 8'h60);
    measure(5000, n);
    check(n == (1 << B), "R2 code0", n, 1 << B);
    do_reset();
    repeat (5) @(negedge clk);
    bus_write(1'b0, 1'b0, 8'h63);
    measure(5000, n);
    check(n == (1 << (B + 3)), "R4 clear R2 code3", n, 1 << (B + 3));

    // R6: good key clears the count
    do_reset();
    bus_write(1'b0, 1'b0, 8'h60);
    repeat (10) @(negedge clk);
    bus_write(1'b1, 1'b0, 8'hAC);
    check(wdt_rst_req == 1'b0, "R6 no req", wdt_rst_req, 0);
    measure(5000, n);
    check(n == (1 << B), "R6 clear", n, 1 << B);

    // R5: second mode write
    do_reset();
    bus_write(1'b0, 1'b0, 8'h61);
    check(wdt_rst_req == 1'b0, "R4", wdt_rst_req, 0);
    bus_write(1'b0, 1'b0, 8'h64);
    check(wdt_rst_req == 1'b1, "R5 req", wdt_rst_req, 1);
    check(bus_rdata == 8'h61, "R5 mode kept", bus_rdata, 8'h61);
    @(negedge clk);
    check(wdt_rst_req == 1'b0, "R11 misuse pulse", wdt_rst_req, 0);

    // R8: bit-access mode write does not use up the single write
    do_reset();
    bus_write(1'b0, 1'b1, 8'h60);
    bus_write(1'b0, 1'b0, 8'h60);
    check(wdt_rst_req == 1'b0, "R8 once kept", wdt_rst_req, 0);
    check(bus_rdata == 8'h60, "R8 once kept mode", bus_rdata, 8'h60);

    // R3: external strobe source, internal ignored
    do_reset();
    int_tick = 1'b1; ext_tick = 1'b0;
    bus_write(1'b0, 1'b0, 8'h68);
    quiet(100, "R3 internal ignored");
    ext_tick = 1'b1; int_tick = 1'b0;
    measure(5000, n);
    check(n == (1 << B), "R3 external", n, 1 << B);
    int_tick = 1'b1;

    // R10: halt freezes and keeps the count
    do_reset();
    bus_write(1'b0, 1'b0, 8'h61);
    repeat (10) @(negedge clk);
    halt = 1'b1;
    quiet(100, "R10 halted");
    halt = 1'b0;
    measure(5000, n);
    check(n == (1 << (B + 1)) - 10, "R10 resume", n, (1 << (B + 1)) - 10);

    // R9/R3: stopped option (bit 3 ignored), no request from anything
    do_reset();
    ext_tick = 1'b1;
    bus_write(1'b0, 1'b0, 8'h78);
    quiet(200, "R3/R9 stopped count");
    bus_write(1'b1, 1'b0, 8'h55);
    check(wdt_rst_req == 1'b0, "R9 wrong key", wdt_rst_req, 0);
    bus_write(1'b1, 1'b1, 8'hAC);
    check(wdt_rst_req == 1'b0, "R9 bit access", wdt_rst_req, 0);
    bus_write(1'b0, 1'b0, 8'h60);
    check(wdt_rst_req == 1'b0, "R9 mode rewrite", wdt_rst_req, 0);
    check(bus_rdata == 8'h78, "R9 mode kept", bus_rdata, 8'h78);
    quiet(50, "R9 after misuse");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule